// File: doc/BRIEF.md
# I2C Target Controller with General-Call Recognition

This block is the target (slave) side of a two-wire serial bus. It watches the clock and data lines through separate input pins, pulls them low through output-enable pins for open-drain pads, and talks to a local host through plain register-style signals. Those signals are a configuration byte that holds the 7-bit own address and a general-call enable, a byte to transmit, the last byte received, a few status flags, an interrupt, and a one-cycle release strobe.

The block detects START and STOP conditions and keeps a bus-busy flag. After a START it shifts in an address byte. The byte is acknowledged when its upper seven bits equal the own address. It is also acknowledged when it is the all-zero general-call byte and that feature is enabled. The read/write bit of the address byte selects whether the data phase runs with the block receiving or transmitting. After every acknowledged byte the block holds the clock line low and raises its interrupt. The bus stays frozen until the host pulses the release strobe. In a read, the byte to transmit is sampled at that release.

A repeated START restarts address reception. A not-acknowledge from the controller ends a read. After that the block stays silent until the next START or STOP. An address byte that does not match, including any 10-bit address header, leaves the block idle until the next START.

Top module: `i2c_target_ctrl`

## Requirements
- R1: `bus_busy_o` goes to 1 after a START (SDA falling while SCL is high) and back to 0 after a STOP (SDA rising while SCL is high). Both conditions are seen through a two-stage input synchronizer.
- R2: The address byte is received most significant bit first. If bits 7:1 equal `own_addr_i[7:1]` (and are not all zero), the block drives SDA low for the 9th clock (ACK) and sets `addressed_o`. If they differ, SDA stays released on the 9th clock and the rest of the transfer is ignored until the next START.
- R3: An all-zero address byte (general call, write) is acknowledged only when `own_addr_i[0]` is 1, and it sets `gc_hit_o`. With `own_addr_i[0]` at 0 it is not acknowledged.
- R4: An address byte whose bits 7:3 are 11110 is never acknowledged, even when bits 7:1 equal the own address.
- R5: After the falling SCL edge that ends the 9th clock of any acknowledged byte, `scl_oe_o` and `irq_o` are 1. They stay 1 until a one-cycle pulse on `host_release_i`, and both are 0 in the cycle after that pulse.
- R6: With bit 0 of the address byte at 0 (write), each following data byte is shifted in MSB first, acknowledged, and presented on `rx_byte_o` by the time the SCL stretch starts.
- R7: With bit 0 of the address byte at 1 (read), `xmit_o` is 1. `tx_byte_i` is sampled at each host release and sent MSB first, and SDA is released after the 8th falling SCL edge so that the controller can drive its acknowledge.
- R8: A NACK (SDA high on the 9th clock) from the controller in a read sets `nack_o`. The block then neither stretches SCL nor drives SDA until the next START or STOP.
- R9: A repeated START in the middle of a transfer starts a new address phase with no STOP in between, and the new read/write bit takes effect.
- R10: After reset `scl_oe_o`, `sda_oe_o`, `irq_o`, `bus_busy_o` and `addressed_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | 8 | Bits 7:1 own address, bit 0 general-call enable |
| tx_byte_i | input | 8 | Byte to send, sampled at host release during a read |
| host_release_i | input | 1 | One-cycle strobe that ends a clock stretch |
| rx_byte_o | output | 8 | Last data byte received |
| irq_o | output | 1 | High while the block stretches SCL and waits for the host |
| bus_busy_o | output | 1 | Bus is between a START and a STOP |
| addressed_o | output | 1 | Current transfer is addressed to this block |
| xmit_o | output | 1 | Read/write bit of the last matched address |
| gc_hit_o | output | 1 | Last match was the general-call address |
| nack_o | output | 1 | The controller answered a transmitted byte with NACK |

## Verification
The hardest situations to reach are the ones where the bench's controller and the block both act on the same wire. Examples are the clock stretch that freezes the controller's next rising edge, and the hand-over of SDA around the acknowledge bit of a read. The bench models the bus as open-drain lines. Its controller releases SCL and waits until the line is actually high. Because of that, a missing or stuck stretch shows up as a changed bit or a hung run. A repeated START is issued right after a host release inside a write. A NACK is given on the second byte of a read, so that the silent wait state is reached with SDA and SCL both still in use.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_RX,
      ST_TX,
      ST_HOLD,
      ST_WAIT
   } tgt_state_e;

   localparam logic [4:0] TENBIT_PREFIX = 5'b11110;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_tgt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic busy
);
   logic [1:0] lines_q;
   logic       scl_prev, sda_prev;

   i2c_tgt_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (lines_q)
   );

   assign scl_s = lines_q[1];
   assign sda_s = lines_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_s;
         sda_prev <= sda_s;
      end
   end

   assign scl_rise  = !scl_prev && scl_s;
   assign scl_fall  = scl_prev && !scl_s;
   assign start_det = scl_prev && scl_s && sda_prev && !sda_s;
   assign stop_det  = scl_prev && scl_s && !sda_prev && sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy <= 1'b0;
      else if (start_det) busy <= 1'b1;
      else if (stop_det)  busy <= 1'b0;
   end

   p_busy_on_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> busy);
   p_idle_on_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !busy);
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter bit GC_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [ADDR_W:0]   own_cfg,
   input  logic [ADDR_W:0]   tx_byte,
   input  logic              host_release,
   output logic [ADDR_W:0]   rx_byte,
   output logic              sda_drv,
   output logic              scl_hold,
   output logic              irq,
   output logic              addressed,
   output logic              xmit,
   output logic              gc_hit,
   output logic              nack
);
   localparam int DATA_W = ADDR_W + 1;
   localparam int CNT_W  = $clog2(DATA_W + 2);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DATA_W + 1);

   generate
      if (ADDR_W != 7) begin : g_bad_addr
         $error("i2c_tgt_engine: only 7-bit addressing is supported");
      end
   endgenerate

   tgt_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sr;
   logic              own_match, gc_match, tenbit, hit;

   assign tenbit    = (sr[DATA_W-1 -: 5] == TENBIT_PREFIX);
   assign own_match = (sr[DATA_W-1:1] == own_cfg[ADDR_W:1]) && (sr[DATA_W-1:1] != '0);

   generate
      if (GC_SUPPORT) begin : g_gc
         assign gc_match = own_cfg[0] && (sr == '0);
      end else begin : g_no_gc
         assign gc_match = 1'b0;
      end
   endgenerate

   assign hit = !tenbit && (own_match || gc_match);
   assign irq = (state == ST_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         sr        <= '0;
         rx_byte   <= '0;
         sda_drv   <= 1'b0;
         scl_hold  <= 1'b0;
         addressed <= 1'b0;
         xmit      <= 1'b0;
         gc_hit    <= 1'b0;
         nack      <= 1'b0;
      end else if (start_det) begin
         state     <= ST_ADDR;
         cnt       <= '0;
         sda_drv   <= 1'b0;
         scl_hold  <= 1'b0;
         addressed <= 1'b0;
         gc_hit    <= 1'b0;
         nack      <= 1'b0;
      end else if (stop_det) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         sda_drv   <= 1'b0;
         scl_hold  <= 1'b0;
         addressed <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR, ST_RX: begin
               if (scl_rise && cnt <= LAST_BIT) begin
                  cnt <= cnt + 1'b1;
                  if (cnt < LAST_BIT) sr <= {sr[DATA_W-2:0], sda_s};
               end else if (scl_fall && cnt == LAST_BIT) begin
                  if (state == ST_RX) begin
                     rx_byte <= sr;
                     sda_drv <= 1'b1;
                  end else if (hit) begin
                     sda_drv   <= 1'b1;
                     addressed <= 1'b1;
                     xmit      <= sr[0];
                     gc_hit    <= gc_match;
                  end else begin
                     state <= ST_IDLE;
                  end
               end else if (scl_fall && cnt == ACK_BIT) begin
                  sda_drv  <= 1'b0;
                  scl_hold <= 1'b1;
                  state    <= ST_HOLD;
                  cnt      <= '0;
               end
            end
            ST_TX: begin
               if (scl_rise && cnt <= LAST_BIT) begin
                  cnt <= cnt + 1'b1;
                  if (cnt == LAST_BIT) nack <= sda_s;
               end else if (scl_fall && cnt != '0 && cnt < LAST_BIT) begin
                  sr      <= {sr[DATA_W-2:0], 1'b0};
                  sda_drv <= !sr[DATA_W-2];
               end else if (scl_fall && cnt == LAST_BIT) begin
                  sda_drv <= 1'b0;
               end else if (scl_fall && cnt == ACK_BIT) begin
                  cnt <= '0;
                  if (nack) begin
                     state <= ST_WAIT;
                  end else begin
                     scl_hold <= 1'b1;
                     state    <= ST_HOLD;
                  end
               end
            end
            ST_HOLD: begin
               if (host_release) begin
                  scl_hold <= 1'b0;
                  cnt      <= '0;
                  if (xmit) begin
                     sr      <= tx_byte;
                     sda_drv <= !tx_byte[DATA_W-1];
                     state   <= ST_TX;
                  end else begin
                     sda_drv <= 1'b0;
                     state   <= ST_RX;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   p_sda_moves_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_drv) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);
   p_stretch_only_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      scl_hold |-> !scl_s);
   p_tenbit_rejected_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR && scl_fall && cnt == LAST_BIT && tenbit && !start_det && !stop_det)
      |=> !addressed);
   p_ack_slot_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TX && cnt == ACK_BIT) |-> !sda_drv);
   p_quiet_after_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> (!sda_drv && !scl_hold));
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl #(
   parameter int SYNC_STAGES = 2,
   parameter bit GC_SUPPORT  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       scl_oe_o,
   output logic       sda_oe_o,
   input  logic [7:0] own_addr_i,
   input  logic [7:0] tx_byte_i,
   input  logic       host_release_i,
   output logic [7:0] rx_byte_o,
   output logic       irq_o,
   output logic       bus_busy_o,
   output logic       addressed_o,
   output logic       xmit_o,
   output logic       gc_hit_o,
   output logic       nack_o
);
   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2c_tgt_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .busy      (bus_busy_o)
   );

   i2c_tgt_engine #(.ADDR_W(7), .GC_SUPPORT(GC_SUPPORT)) u_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_s        (scl_s),
      .sda_s        (sda_s),
      .scl_rise     (scl_rise),
      .scl_fall     (scl_fall),
      .start_det    (start_det),
      .stop_det     (stop_det),
      .own_cfg      (own_addr_i),
      .tx_byte      (tx_byte_i),
      .host_release (host_release_i),
      .rx_byte      (rx_byte_o),
      .sda_drv      (sda_oe_o),
      .scl_hold     (scl_oe_o),
      .irq          (irq_o),
      .addressed    (addressed_o),
      .xmit         (xmit_o),
      .gc_hit       (gc_hit_o),
      .nack         (nack_o)
   );

   p_irq_tracks_stretch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && host_release_i) |=> (!scl_oe_o && !irq_o));
endmodule

// File: tb/i2c_target_ctrl_bench.sv
module i2c_target_ctrl_bench;
   localparam int Q = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic scl_oe, sda_oe;
   logic [7:0] own_addr = 8'h55;
   logic [7:0] tx_byte = 8'h00;
   logic host_release = 1'b0;
   logic [7:0] rx_byte;
   logic irq, busy, addressed, xmit, gc_hit, nack;
   logic scl_line, sda_line;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #10 clk = !clk;

   assign scl_line = !(m_scl_low || scl_oe);
   assign sda_line = !(m_sda_low || sda_oe);

   i2c_target_ctrl u_i2c_target_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(own_addr),
      .tx_byte_i(tx_byte), .host_release_i(host_release), .rx_byte_o(rx_byte),
      .irq_o(irq), .bus_busy_o(busy), .addressed_o(addressed), .xmit_o(xmit),
      .gc_hit_o(gc_hit), .nack_o(nack)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Reference model of the bus-busy flag: line history through the two-stage input path
   logic [2:0] h_scl = 3'b111, h_sda = 3'b111;
   logic model_busy = 1'b0;
   always @(posedge clk) begin
      if (!rst_n) begin
         h_scl <= 3'b111; h_sda <= 3'b111; model_busy <= 1'b0;
      end else begin
         if (h_scl[1] && h_scl[2] && h_sda[2] && !h_sda[1]) model_busy <= 1'b1;
         else if (h_scl[1] && h_scl[2] && !h_sda[2] && h_sda[1]) model_busy <= 1'b0;
         h_scl <= {h_scl[1:0], scl_line};
         h_sda <= {h_sda[1:0], sda_line};
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (rst_n) check("R1 busy per cycle", busy, model_busy);
      if (cycles > 150000) begin
         failures++;
         $display("FAIL R5 watchdog actual=hung expected=progress");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic wq(int n); repeat (n) @(negedge clk); endtask

   task automatic raise_scl();
      m_scl_low = 1'b0;
      while (!scl_line) @(negedge clk);
   endtask

   task automatic do_start();
      m_sda_low = 1'b0; wq(Q);
      raise_scl(); wq(Q);
      m_sda_low = 1'b1; wq(Q);
      m_scl_low = 1'b1; wq(Q);
   endtask

   task automatic do_stop();
      m_sda_low = 1'b1; wq(Q);
      raise_scl(); wq(Q);
      m_sda_low = 1'b0; wq(Q);
   endtask

   task automatic send_bit(logic b);
      m_sda_low = !b; wq(Q);
      raise_scl(); wq(Q);
      m_scl_low = 1'b1; wq(Q);
   endtask

   task automatic read_bit(output logic b);
      m_sda_low = 1'b0; wq(Q);
      raise_scl(); wq(Q / 2);
      b = sda_line; wq(Q / 2);
      m_scl_low = 1'b1; wq(Q);
   endtask

   task automatic send_byte(logic [7:0] v, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      read_bit(b);
      acked = !b;
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         read_bit(b);
         v[i] = b;
      end
      send_bit(!give_ack);
   endtask

   task automatic release_host();
      host_release = 1'b1; @(negedge clk);
      host_release = 1'b0;
   endtask

   initial begin
      logic ack;
      logic [7:0] got;
      wq(5);
      check("R10 scl_oe reset", scl_oe, 0);
      check("R10 sda_oe reset", sda_oe, 0);
      check("R10 irq reset", irq, 0);
      check("R10 busy reset", busy, 0);
      check("R10 addressed reset", addressed, 0);
      rst_n = 1'b1; wq(5);

      // Write transfer to own address 0x2A (config 0x55, general call on)
      do_start();
      check("R1 busy after START", busy, 1);
      send_byte(8'h54, ack);
      check("R2 address ACK", ack, 1);
      check("R2 addressed", addressed, 1);
      check("R5 stretch after address", scl_oe, 1);
      check("R5 irq after address", irq, 1);
      check("R6 write direction", xmit, 0);
      wq(20);
      check("R5 stretch persists", scl_oe, 1);
      release_host();
      check("R5 released", scl_oe, 0);
      check("R5 irq cleared", irq, 0);
      send_byte(8'hA5, ack);
      check("R6 data ACK", ack, 1);
      check("R6 rx byte A5", rx_byte, 8'hA5);
      check("R5 stretch after data", scl_oe, 1);
      release_host();
      send_byte(8'h3C, ack);
      check("R6 rx byte 3C", rx_byte, 8'h3C);
      release_host();
      do_stop();
      wq(4);
      check("R1 idle after STOP", busy, 0);

      // Non-matching address is ignored
      do_start();
      send_byte(8'h22, ack);
      check("R2 mismatch NACK", ack, 0);
      check("R2 mismatch no stretch", scl_oe, 0);
      send_byte(8'hFF, ack);
      check("R2 data ignored", ack, 0);
      check("R2 rx unchanged", rx_byte, 8'h3C);
      do_stop();

      // General call enabled
      do_start();
      send_byte(8'h00, ack);
      check("R3 general call ACK", ack, 1);
      check("R3 gc flag", gc_hit, 1);
      release_host();
      send_byte(8'h96, ack);
      check("R3 gc data", rx_byte, 8'h96);
      release_host();
      do_stop();

      // General call disabled
      own_addr = 8'h54;
      do_start();
      send_byte(8'h00, ack);
      check("R3 general call off NACK", ack, 0);
      check("R3 no stretch", scl_oe, 0);
      do_stop();

      // 10-bit header equal to own address bits
      own_addr = 8'hF1;
      do_start();
      send_byte(8'hF0, ack);
      check("R4 ten-bit header NACK", ack, 0);
      check("R4 not addressed", addressed, 0);
      do_stop();

      // Read transfer with NACK on second byte
      own_addr = 8'h55;
      do_start();
      send_byte(8'h55, ack);
      check("R7 read address ACK", ack, 1);
      check("R7 read direction", xmit, 1);
      tx_byte = 8'hC3;
      release_host();
      tx_byte = 8'h00;
      recv_byte(got, 1'b1);
      check("R7 first byte", got, 8'hC3);
      check("R5 stretch after read ACK", scl_oe, 1);
      tx_byte = 8'h5A;
      release_host();
      recv_byte(got, 1'b0);
      check("R7 second byte", got, 8'h5A);
      check("R8 nack flag", nack, 1);
      check("R8 no stretch", scl_oe, 0);
      check("R8 sda free", sda_oe, 0);
      check("R8 no irq", irq, 0);
      do_stop();

      // Repeated START switches from write to read
      do_start();
      send_byte(8'h54, ack);
      release_host();
      check("R9 write phase", xmit, 0);
      do_start();
      check("R9 busy kept", busy, 1);
      send_byte(8'h55, ack);
      check("R9 readdress ACK", ack, 1);
      check("R9 read direction", xmit, 1);
      tx_byte = 8'h81;
      release_host();
      recv_byte(got, 1'b0);
      check("R9 byte after restart", got, 8'h81);
      do_stop();
      wq(4);
      check("R1 final idle", busy, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule